// File: doc/BRIEF.md
# Six-Stage Pipelined Floating-Point Adder

This block adds two single-precision floating-point numbers in a fixed pipeline of six one-cycle stages. A new operand pair may be presented on every clock cycle. Each pair is tagged by a valid flag that travels with it. Exactly six cycles later the sum appears at the output with its own valid flag. Once the pipeline is full, one sum leaves on every cycle.

The stages run in this order:

1. Stage 1 unpacks both words into sign, exponent and significand. The hidden one is restored here.
2. Stage 2 compares magnitudes. It orders the operands into a larger and a smaller one and forms the exponent difference.
3. Stage 3 shifts the smaller significand right by that difference.
4. Stage 4 adds the two significands, or subtracts them when the signs differ.
5. Stage 5 normalizes the sum. It selects one of four named actions: `NORM_KEEP` (already normalized), `NORM_RIGHT` (carry out, shift right by one), `NORM_LEFT` (cancellation, shift left by the leading-zero count) and `NORM_ZERO` (empty sum).
6. Stage 6 packs the result into a 32-bit word.

The block rounds by truncation. It has no special handling for infinities or NaNs. It has no subnormal support and no flow control.

Top module: `fp_add_pipe6`

## Requirements
- R1: Operands and result share one word layout. The sign is bit 31 (1 = negative). The biased exponent (bias 127) is bits 30:23. The fraction is bits 22:0, with an implied leading one for every nonzero value.
- R2: `out_valid` is high in a cycle exactly when `in_valid` was high six clock cycles earlier. The sum for that operand pair is on `out_sum` in that same cycle.
- R3: Operand pairs may be presented on consecutive cycles with no gap. The sums then leave on consecutive cycles, in the order the pairs entered.
- R4: For operands of equal sign, the significands are added. If the addition carries out, the result is shifted right by one and its exponent is raised by one. Example: 1.75 + 1.75 gives 0x40600000.
- R5: When the exponents differ, the significand of the operand with the smaller magnitude is shifted right by the exponent difference before the add. If the difference is 24 or more, that operand contributes nothing.
- R6: For operands of opposite sign, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger-magnitude operand.
- R7: After a cancellation, the result is shifted left until its leading one is in the hidden position, and the exponent is lowered by the same amount. If the exponent would reach zero or below, the result is positive zero.
- R8: Bits shifted out during alignment or normalization are discarded (truncation). The result is never rounded up.
- R9: An operand whose exponent field is 0 is taken as zero, whatever its fraction bits. Any zero result is encoded as 0x00000000 (positive zero).
- R10: While `rst_n` is low, `out_valid` is low. After reset is released, no valid output appears unless a valid input entered six cycles before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_a` and `in_b` as an operand pair this cycle |
| in_a | input | 32 | First operand, single-precision layout |
| in_b | input | 32 | Second operand, single-precision layout |
| out_valid | output | 1 | Marks `out_sum` as a result this cycle |
| out_sum | output | 32 | Sum, single-precision layout |

## Verification
A corrupted valid chain shows at the ports within six cycles. The fault appears as `out_valid` either missing from, or present in, a cycle where the input history says otherwise. Each cycle's pattern is therefore compared against the inputs sent six cycles earlier, including pairs separated by gaps. A wrong ordering, alignment or normalization decision appears six cycles after the offending pair, as a wrong sign, exponent or fraction in one result word. For this reason, directed pairs cover each normalization action, both sign cases, alignment boundaries at 23 and 24 bits, and truncation in both alignment and cancellation. Back-to-back streams catch stage registers that mix neighbouring operations.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    // Normalization action chosen in stage 5
    typedef enum logic [1:0] {
        NORM_KEEP  = 2'd0,
        NORM_RIGHT = 2'd1,
        NORM_LEFT  = 2'd2,
        NORM_ZERO  = 2'd3
    } norm_act_e;

    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;

endpackage

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
    parameter int W  = 24,
    parameter int CW = 5
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    // The highest set bit wins because the loop runs upward from bit 0.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/fpadd_order.sv
module fpadd_order #(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24
) (
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] a_mant,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [MANT_W-1:0] b_mant,
    output logic              big_sign,
    output logic [EXP_W-1:0]  big_exp,
    output logic [MANT_W-1:0] big_mant,
    output logic [MANT_W-1:0] small_mant,
    output logic [EXP_W-1:0]  exp_diff,
    output logic              eff_sub
);

    logic a_is_big;

    // Magnitude order: exponent first, then significand (R6).
    // On a tie, operand a is taken as the larger one.
    assign a_is_big = {a_exp, a_mant} >= {b_exp, b_mant};

    always_comb begin
        if (a_is_big) begin
            big_sign   = a_sign;
            big_exp    = a_exp;
            big_mant   = a_mant;
            small_mant = b_mant;
            exp_diff   = a_exp - b_exp;
        end else begin
            big_sign   = b_sign;
            big_exp    = b_exp;
            big_mant   = b_mant;
            small_mant = a_mant;
            exp_diff   = b_exp - a_exp;
        end
        eff_sub = a_sign ^ b_sign;
    end

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24
) (
    input  logic              sign_in,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [MANT_W:0]   sum_in,
    output norm_act_e         act,
    output logic              sign_out,
    output logic [EXP_W-1:0]  exp_out,
    output logic [MANT_W-1:0] mant_out
);

    localparam int LZ_W = $clog2(MANT_W + 1);

    logic [LZ_W-1:0] lead_zeros;

    fpadd_lzc #(
        .W  (MANT_W),
        .CW (LZ_W)
    ) u_lzc (
        .vec   (sum_in[MANT_W-1:0]),
        .count (lead_zeros)
    );

    // Action selection
    always_comb begin
        if (sum_in == '0) begin
            act = NORM_ZERO;
        end else if (sum_in[MANT_W]) begin
            act = NORM_RIGHT;
        end else if (sum_in[MANT_W-1]) begin
            act = NORM_KEEP;
        end else begin
            act = NORM_LEFT;
        end
    end

    // Result for each action
    always_comb begin
        sign_out = sign_in;
        exp_out  = exp_in;
        mant_out = sum_in[MANT_W-1:0];
        unique case (act)
            NORM_KEEP: begin
                mant_out = sum_in[MANT_W-1:0];
            end
            NORM_RIGHT: begin
                // R4: carry out; the lowest bit is dropped (R8)
                mant_out = sum_in[MANT_W:1];
                exp_out  = exp_in + 1'b1;
            end
            NORM_LEFT: begin
                // R7: left shift by the leading-zero count, flush on underflow
                if (exp_in > EXP_W'(lead_zeros)) begin
                    mant_out = sum_in[MANT_W-1:0] << lead_zeros;
                    exp_out  = exp_in - EXP_W'(lead_zeros);
                end else begin
                    sign_out = 1'b0;
                    exp_out  = '0;
                    mant_out = '0;
                end
            end
            NORM_ZERO: begin
                // R9: positive zero
                sign_out = 1'b0;
                exp_out  = '0;
                mant_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/fp_add_pipe6.sv
module fp_add_pipe6
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   in_a,
    input  logic [EXP_W+FRAC_W:0]   in_b,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   out_sum
);

    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int STAGES  = 6;
    localparam int CNT_W   = $clog2(STAGES + 1);

    // ---------------- valid chain (R2, R3, R10) ----------------
    logic [STAGES:1] vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld <= {vld[STAGES-1:1], in_valid};
        end
    end

    assign out_valid = vld[STAGES];

    // ---------------- stage 1: unpack (R1, R9) ----------------
    logic              s1_a_sign, s1_b_sign;
    logic [EXP_W-1:0]  s1_a_exp, s1_b_exp;
    logic [MANT_W-1:0] s1_a_mant, s1_b_mant;
    logic [EXP_W-1:0]  a_exp_fld, b_exp_fld;

    assign a_exp_fld = in_a[FRAC_W +: EXP_W];
    assign b_exp_fld = in_b[FRAC_W +: EXP_W];

    always_ff @(posedge clk) begin
        s1_a_sign <= in_a[WORD_W-1];
        s1_b_sign <= in_b[WORD_W-1];
        s1_a_exp  <= a_exp_fld;
        s1_b_exp  <= b_exp_fld;
        s1_a_mant <= (a_exp_fld == '0) ? '0 : {1'b1, in_a[FRAC_W-1:0]};
        s1_b_mant <= (b_exp_fld == '0) ? '0 : {1'b1, in_b[FRAC_W-1:0]};
    end

    // ---------------- stage 2: compare exponents (R6) ----------------
    logic              ord_big_sign, ord_sub;
    logic [EXP_W-1:0]  ord_big_exp, ord_diff;
    logic [MANT_W-1:0] ord_big_mant, ord_small_mant;

    fpadd_order #(
        .EXP_W  (EXP_W),
        .MANT_W (MANT_W)
    ) u_order (
        .a_sign     (s1_a_sign),
        .a_exp      (s1_a_exp),
        .a_mant     (s1_a_mant),
        .b_sign     (s1_b_sign),
        .b_exp      (s1_b_exp),
        .b_mant     (s1_b_mant),
        .big_sign   (ord_big_sign),
        .big_exp    (ord_big_exp),
        .big_mant   (ord_big_mant),
        .small_mant (ord_small_mant),
        .exp_diff   (ord_diff),
        .eff_sub    (ord_sub)
    );

    logic              s2_sign, s2_sub;
    logic [EXP_W-1:0]  s2_exp, s2_diff;
    logic [MANT_W-1:0] s2_big, s2_small;

    always_ff @(posedge clk) begin
        s2_sign  <= ord_big_sign;
        s2_sub   <= ord_sub;
        s2_exp   <= ord_big_exp;
        s2_diff  <= ord_diff;
        s2_big   <= ord_big_mant;
        s2_small <= ord_small_mant;
    end

    // ---------------- stage 3: align (R5, R8) ----------------
    logic              s3_sign, s3_sub;
    logic [EXP_W-1:0]  s3_exp;
    logic [MANT_W-1:0] s3_big, s3_small;

    always_ff @(posedge clk) begin
        s3_sign  <= s2_sign;
        s3_sub   <= s2_sub;
        s3_exp   <= s2_exp;
        s3_big   <= s2_big;
        s3_small <= (int'(s2_diff) >= MANT_W) ? '0 : (s2_small >> s2_diff);
    end

    // ---------------- stage 4: add or subtract (R4, R6) ----------------
    logic              s4_sign;
    logic [EXP_W-1:0]  s4_exp;
    logic [MANT_W:0]   s4_sum;

    always_ff @(posedge clk) begin
        s4_sign <= s3_sign;
        s4_exp  <= s3_exp;
        if (s3_sub) begin
            s4_sum <= {1'b0, s3_big} - {1'b0, s3_small};
        end else begin
            s4_sum <= {1'b0, s3_big} + {1'b0, s3_small};
        end
    end

    // ---------------- stage 5: normalize (R4, R7, R9) ----------------
    norm_act_e         nrm_act;
    logic              nrm_sign;
    logic [EXP_W-1:0]  nrm_exp;
    logic [MANT_W-1:0] nrm_mant;

    fpadd_norm #(
        .EXP_W  (EXP_W),
        .MANT_W (MANT_W)
    ) u_norm (
        .sign_in  (s4_sign),
        .exp_in   (s4_exp),
        .sum_in   (s4_sum),
        .act      (nrm_act),
        .sign_out (nrm_sign),
        .exp_out  (nrm_exp),
        .mant_out (nrm_mant)
    );

    logic              s5_sign;
    logic [EXP_W-1:0]  s5_exp;
    logic [MANT_W-1:0] s5_mant;
    norm_act_e         s5_act;

    always_ff @(posedge clk) begin
        s5_sign <= nrm_sign;
        s5_exp  <= nrm_exp;
        s5_mant <= nrm_mant;
        s5_act  <= nrm_act;
    end

    // ---------------- stage 6: pack (R1) ----------------
    always_ff @(posedge clk) begin
        out_sum <= {s5_sign, s5_exp, s5_mant[FRAC_W-1:0]};
    end

    // ---------------- checks ----------------
    logic [CNT_W-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != CNT_W'(STAGES)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CNT_W'(STAGES)) |-> (out_valid == $past(in_valid, 6)));

    assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vld[3] |-> (s3_big >= s3_small));

    assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[3] && (int'($past(s2_diff)) >= MANT_W)) |-> (s3_small == '0));

    assert_norm_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[5] && s5_exp != '0) |-> s5_mant[MANT_W-1]);

    assert_norm_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[5] && s5_act == NORM_ZERO) |-> (s5_exp == '0 && !s5_sign));

    assert_zero_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sum[FRAC_W +: EXP_W] == '0) |-> (out_sum == '0));

endmodule

// File: tb/fp_add_pipe6_tb.sv
module fp_add_pipe6_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_sum;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    // expectation attached to the pair currently driven
    logic [31:0] cur_exp = '0;
    string       cur_tag = "";

    // six-deep history of what was driven
    logic        hist_v [6];
    logic [31:0] hist_e [6];
    string       hist_t [6];

    always #5 clk = ~clk;

    fp_add_pipe6 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    // Monitor: sample 1 ns after each falling edge.
    // The output seen now belongs to the pair driven six samples earlier (R2).
    initial begin
        for (int i = 0; i < 6; i++) begin
            hist_v[i] = 1'b0;
            hist_e[i] = '0;
            hist_t[i] = "";
        end
        forever begin
            @(negedge clk);
            #1;
            if (mon_on) begin
                checks++;
                if (out_valid !== hist_v[5]) begin
                    errors++;
                    $display("FAIL R2 out_valid: actual %b expected %b", out_valid, hist_v[5]);
                end
                if (hist_v[5]) begin
                    checks++;
                    if (out_sum !== hist_e[5]) begin
                        errors++;
                        $display("FAIL %s out_sum: actual %h expected %h",
                                 hist_t[5], out_sum, hist_e[5]);
                    end
                end
                for (int i = 5; i > 0; i--) begin
                    hist_v[i] = hist_v[i-1];
                    hist_e[i] = hist_e[i-1];
                    hist_t[i] = hist_t[i-1];
                end
                hist_v[0] = in_valid;
                hist_e[0] = cur_exp;
                hist_t[0] = cur_tag;
            end
        end
    end

    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] expv, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        cur_exp  = expv;
        cur_tag  = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a     = 32'hDEAD_BEEF;
            in_b     = 32'h1234_5678;
            cur_exp  = '0;
            cur_tag  = "";
        end
    endtask

    task automatic test_reset();
        // R10: out_valid low during reset even with inputs toggling
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = 32'h3F80_0000;
        in_b = 32'h3F80_0000;
        repeat (8) begin
            @(negedge clk);
            #1;
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R10 out_valid in reset: actual %b expected 0", out_valid);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        idle(8); // R10: no output without input
    endtask

    task automatic test_equal_exp();
        issue(32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, "R4 1+1");
        issue(32'h3FE0_0000, 32'h3FE0_0000, 32'h4060_0000, "R4 1.75+1.75");
        issue(32'h3F80_0000, 32'h3FC0_0000, 32'h4020_0000, "R4 1+1.5");
        issue(32'hBFC0_0000, 32'hC020_0000, 32'hC080_0000, "R4 -1.5+-2.5");
        idle(7);
    endtask

    task automatic test_unequal_exp();
        issue(32'h3FC0_0000, 32'h4020_0000, 32'h4080_0000, "R5 1.5+2.5");
        issue(32'h3F80_0000, 32'h4E80_0000, 32'h4E80_0000, "R5 diff 30");
        issue(32'h40A0_0000, 32'h3F80_0000, 32'h40C0_0000, "R5 5+1");
        idle(7);
    endtask

    task automatic test_opposite();
        issue(32'h4040_0000, 32'hBF80_0000, 32'h4000_0000, "R6 3-1");
        issue(32'h3F80_0000, 32'hC040_0000, 32'hC000_0000, "R6 1-3");
        idle(7);
    endtask

    task automatic test_cancel();
        issue(32'h3FC0_0000, 32'hBFA0_0000, 32'h3E80_0000, "R7 1.5-1.25");
        issue(32'h3F80_0000, 32'hBF7F_FFFF, 32'h3400_0000, "R7 1-(1-ulp)");
        issue(32'h0080_0001, 32'h8080_0000, 32'h0000_0000, "R7 underflow flush");
        idle(7);
    endtask

    task automatic test_trunc();
        issue(32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000, "R8 diff 24 dropped");
        issue(32'h3F80_0000, 32'h3440_0000, 32'h3F80_0001, "R8 diff 23 truncated");
        issue(32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFF, "R8 carry lsb dropped");
        idle(7);
    endtask

    task automatic test_zero();
        issue(32'h0000_0000, 32'h40A0_0000, 32'h40A0_0000, "R9 0+5");
        issue(32'h0000_0001, 32'h3F80_0000, 32'h3F80_0000, "R9 exp0 frac ignored");
        issue(32'hC000_0000, 32'h4000_0000, 32'h0000_0000, "R9 -2+2 is +0");
        issue(32'h8000_0000, 32'h8000_0000, 32'h0000_0000, "R9 -0+-0 is +0");
        idle(7);
    endtask

    task automatic test_stream();
        // R3: back-to-back pairs, results in order
        issue(32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, "R3 s0");
        issue(32'h4040_0000, 32'hBF80_0000, 32'h4000_0000, "R3 s1");
        issue(32'h3FC0_0000, 32'hBFA0_0000, 32'h3E80_0000, "R3 s2");
        issue(32'h0000_0000, 32'h40A0_0000, 32'h40A0_0000, "R3 s3");
        issue(32'hBFC0_0000, 32'hC020_0000, 32'hC080_0000, "R3 s4");
        issue(32'h3F80_0000, 32'h3440_0000, 32'h3F80_0001, "R3 s5");
        issue(32'hC000_0000, 32'h4000_0000, 32'h0000_0000, "R3 s6");
        issue(32'h3F80_0000, 32'hC040_0000, 32'hC000_0000, "R3 s7");
        idle(7);
    endtask

    task automatic test_gaps();
        // R2: valid pattern with bubbles must reappear six cycles later
        issue(32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, "R2 g0");
        idle(2);
        issue(32'h40A0_0000, 32'h3F80_0000, 32'h40C0_0000, "R2 g1");
        idle(1);
        issue(32'h3FE0_0000, 32'h3FE0_0000, 32'h4060_0000, "R2 g2");
        idle(3);
        issue(32'h3F80_0000, 32'hC040_0000, 32'hC000_0000, "R2 g3");
        idle(8);
    endtask

    initial begin
        test_reset();
        test_equal_exp();
        test_unequal_exp();
        test_opposite();
        test_cancel();
        test_trunc();
        test_zero();
        test_stream();
        test_gaps();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule